// File: doc/BRIEF.md
# Coalescing Stratum Write Cache

This block holds the stores one core makes during a stratum of deterministic execution. Program store order is deliberately dropped. Each store is placed in a set-associative array of line entries, and a later store to a line that is already held is folded into that entry byte by byte. The core's own loads consult the array during the execute phase. Buffered bytes are laid over the data the L1 returns, so the core sees its own pending writes.

When the phase input switches to publish, loads are refused and stores are held off. A scanner then walks every entry from index zero upward and sends each valid line out on a valid/ready stream. The entry index is set times ways plus way. After the last index the scanner emits a one-cycle done pulse, and the array is then empty. A store that misses a set with no free way raises a stall on the store port in the same cycle. It also sets an overflow flag that asks the surrounding logic to end the stratum. The core replays that store once the flush is over and execute resumes.

Line addresses are given in whole lines. The set is the low address bits and the tag is the rest. The phase input is assumed to stay in publish until the done pulse has been seen.

Top module: `wcache_coalesce`

## Requirements
- R1: After reset no line is buffered: fl_valid, flush_done, overflow and st_stall are 0, and a load returns ld_l1_data unchanged.
- R2: A store that misses during execute, to a set with a free way, takes the lowest-numbered free way of set (st_addr mod SETS). The new entry keeps only the masked bytes, and its unmasked bytes read as zero when flushed.
- R3: A store that hits a buffered line during execute merges into that entry without a new allocation. Each byte with its st_mask bit set is replaced, and the entry mask becomes the OR of the old mask and st_mask.
- R4: During execute, ld_refused is 0. For a load that hits, byte b of ld_data is the buffered byte where the entry mask bit b is set, and the ld_l1_data byte elsewhere. A miss returns ld_l1_data. Forwarding reflects stores accepted in earlier cycles.
- R5: While phase_publish is 1, a valid load gives ld_refused = 1 and ld_data = ld_l1_data.
- R6: A store during execute that misses a set whose ways are all valid raises st_stall in the same cycle and writes nothing. overflow becomes 1 on the next cycle and stays 1 until the flush completes.
- R7: While phase_publish is 1, every valid store gets st_stall = 1 and is not written.
- R8: The flush presents the valid entries in ascending index order (set*WAYS + way). It presents one line per accepted handshake, with fl_addr = full line address and fl_data/fl_mask as buffered. A line that is not accepted is held unchanged.
- R9: flush_done is a single-cycle pulse that follows the handshake of the last valid entry, or the scan of an empty array. When it is seen, all entries are invalid and overflow is 0.
- R10: Once phase_publish returns to 0 after the done pulse, a replayed store that stalled before the flush is accepted without stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_publish | input | 1 | 0 = execute phase, 1 = publish phase |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store line address |
| st_data | input | LINE_BYTES*8 | Store data, byte lanes across the line |
| st_mask | input | LINE_BYTES | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load line address |
| ld_l1_data | input | LINE_BYTES*8 | Line data from the L1 |
| ld_data | output | LINE_BYTES*8 | Line data with buffered bytes applied |
| ld_refused | output | 1 | Load rejected because publish is active |
| fl_valid | output | 1 | Flush line offered |
| fl_ready | input | 1 | Flush line accepted |
| fl_addr | output | ADDR_W | Flushed line address |
| fl_data | output | LINE_BYTES*8 | Flushed line data |
| fl_mask | output | LINE_BYTES | Flushed byte enables |
| flush_done | output | 1 | One-cycle pulse at flush completion |
| overflow | output | 1 | A store found its set full; the stratum must end |

## Verification
The bench builds the block with SETS=2, WAYS=2, LINE_BYTES=4 and ADDR_W=8, so four entries cover the whole array. A third line mapped to one set is then enough to reach overflow. All fifteen non-zero byte masks can be swept through merging and forwarding on one line. Each flush scan visits every index in a few cycles, which lets the bench predict the exact line order and the done cycle for full, partly filled and empty arrays, with stuttering and steady ready patterns.

// File: rtl/wc_pkg.sv
// Package wc_pkg: types shared by the coalescing write cache modules.
// Assumes nothing beyond IEEE 1800-2017 enums.
package wc_pkg;

    // Byte lane width used for every mask bit.
    localparam int BYTE_W = 8;

    // Flush scanner states.
    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_SCAN = 2'd1,
        FL_DONE = 2'd2
    } wc_fl_state_e;

endpackage

// File: rtl/wc_lookup.sv
// Module wc_lookup: compares one set's tags against a key and reports
// the hitting way. Assumes at most one way of a set holds a given tag
// (kept true by the allocator) and WAYS is a power of two, at least 2.
module wc_lookup #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20
) (
    input  logic [WAYS-1:0]         way_vld,
    input  logic [WAYS*TAG_W-1:0]   way_tags,
    input  logic [TAG_W-1:0]        key,
    output logic [WAYS-1:0]         hit_vec,
    output logic                    hit,
    output logic [$clog2(WAYS)-1:0] hit_way
);

    localparam int WAY_W = $clog2(WAYS);

    // Per-way tag compare, one comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_vld[g] && (way_tags[g*TAG_W +: TAG_W] == key);
    end

    assign hit = |hit_vec;

    // Encode the hitting way, lowest index wins.
    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

endmodule

// File: rtl/wc_alloc.sv
// Module wc_alloc: picks the lowest-numbered free way of a set and flags
// a set with no free way. Assumes WAYS is a power of two, at least 2.
module wc_alloc #(
    parameter int WAYS = 8
) (
    input  logic [WAYS-1:0]         way_vld,
    output logic                    full,
    output logic [$clog2(WAYS)-1:0] free_way
);

    localparam int WAY_W = $clog2(WAYS);

    assign full = &way_vld;

    // Priority pick of the first empty way.
    always_comb begin
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_vld[i]) free_way = WAY_W'(i);
        end
    end

endmodule

// File: rtl/wc_merge.sv
// Module wc_merge: byte-lane overlay. Each output byte is taken from
// 'over' when its mask bit is set and from 'base' otherwise. Pure logic.
module wc_merge #(
    parameter int LINE_BYTES = 8
) (
    input  logic [LINE_BYTES*8-1:0] base,
    input  logic [LINE_BYTES*8-1:0] over,
    input  logic [LINE_BYTES-1:0]   mask,
    output logic [LINE_BYTES*8-1:0] result
);

    // One byte multiplexer per lane.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        assign result[b*8 +: 8] = mask[b] ? over[b*8 +: 8] : base[b*8 +: 8];
    end

endmodule

// File: rtl/wc_flush_ctrl.sv
// Module wc_flush_ctrl: publish-phase scanner. On entry to publish it walks
// entry indices from 0 to the last, offering each valid entry and waiting
// for its handshake, skipping invalid ones at one index per cycle. After
// the last index it pulses done and waits for publish to drop.
// Assumes publish stays high until done has pulsed.
module wc_flush_ctrl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             publish,
    input  logic             ent_valid,
    input  logic             fl_ready,
    output logic [IDX_W-1:0] ptr,
    output logic             fl_valid,
    output logic             clear_en,
    output logic             scan_end,
    output logic             done
);

    import wc_pkg::*;

    wc_fl_state_e     state_q;
    logic [IDX_W-1:0] ptr_q;
    logic             done_q;
    logic             step;

    // Advance when the current index is empty or its line is taken.
    assign step     = (state_q == FL_SCAN) && (!ent_valid || fl_ready);
    assign scan_end = step && (ptr_q == {IDX_W{1'b1}});
    assign fl_valid = (state_q == FL_SCAN) && ent_valid;
    assign clear_en = fl_valid && fl_ready;
    assign ptr      = ptr_q;
    assign done     = done_q;

    // Scanner state, index pointer and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            ptr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= scan_end;
            case (state_q)
                FL_IDLE: begin
                    if (publish) begin
                        state_q <= FL_SCAN;
                        ptr_q   <= '0;
                    end
                end
                FL_SCAN: begin
                    if (scan_end)  state_q <= FL_DONE;
                    else if (step) ptr_q   <= ptr_q + IDX_W'(1);
                end
                FL_DONE: begin
                    if (!publish) state_q <= FL_IDLE;
                end
                default: state_q <= FL_IDLE;
            endcase
        end
    end

    // R8: an offered line that is not taken stays offered at the same index.
    a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_ready) |=> (fl_valid && $stable(ptr_q)));

    // R9: the completion indication lasts exactly one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/wcache_coalesce.sv
// Module wcache_coalesce: per-core unordered coalescing store buffer for one
// stratum. Stores allocate or merge into a SETS x WAYS array of line
// entries; loads overlay buffered bytes on L1 data during execute; in
// publish the whole array is streamed out in index order and cleared.
// Assumes SETS and WAYS are powers of two (each at least 2), addresses are
// line addresses, and phase_publish is held until flush_done has pulsed.
module wcache_coalesce #(
    parameter int SETS       = 8,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 8,
    parameter int ADDR_W     = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    phase_publish,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [LINE_BYTES*8-1:0] st_data,
    input  logic [LINE_BYTES-1:0]   st_mask,
    output logic                    st_stall,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [LINE_BYTES*8-1:0] ld_l1_data,
    output logic [LINE_BYTES*8-1:0] ld_data,
    output logic                    ld_refused,
    output logic                    fl_valid,
    input  logic                    fl_ready,
    output logic [ADDR_W-1:0]       fl_addr,
    output logic [LINE_BYTES*8-1:0] fl_data,
    output logic [LINE_BYTES-1:0]   fl_mask,
    output logic                    flush_done,
    output logic                    overflow
);

    localparam int ENTRIES = SETS * WAYS;
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int IDX_W   = SET_W + WAY_W;
    localparam int TAG_W   = ADDR_W - SET_W;
    localparam int LINE_W  = LINE_BYTES * 8;

    // Entry storage.
    logic [ENTRIES-1:0]    vld_q;
    logic [TAG_W-1:0]      tag_q  [ENTRIES];
    logic [LINE_W-1:0]     data_q [ENTRIES];
    logic [LINE_BYTES-1:0] mask_q [ENTRIES];
    logic                  ovf_q;

    // Store path signals.
    logic [SET_W-1:0]       st_set;
    logic [TAG_W-1:0]       st_tag;
    logic [WAYS-1:0]        st_way_vld;
    logic [WAYS*TAG_W-1:0]  st_way_tags;
    logic [WAYS-1:0]        st_hit_vec;
    logic                   st_hit;
    logic [WAY_W-1:0]       st_hit_way;
    logic                   st_full;
    logic [WAY_W-1:0]       st_free_way;
    logic [IDX_W-1:0]       st_idx;
    logic                   st_ok;
    logic                   ovf_set;
    logic [LINE_W-1:0]      st_base;
    logic [LINE_W-1:0]      st_merged;

    // Load path signals.
    logic [SET_W-1:0]       ld_set;
    logic [TAG_W-1:0]       ld_tag;
    logic [WAYS-1:0]        ld_way_vld;
    logic [WAYS*TAG_W-1:0]  ld_way_tags;
    logic [WAYS-1:0]        ld_hit_vec;
    logic                   ld_hit;
    logic [WAY_W-1:0]       ld_hit_way;
    logic [IDX_W-1:0]       ld_idx;
    logic [LINE_W-1:0]      ld_merged;

    // Flush path signals.
    logic [IDX_W-1:0]       fl_ptr;
    logic                   fl_clear;
    logic                   fl_scan_end;

    assign st_set = st_addr[SET_W-1:0];
    assign st_tag = st_addr[ADDR_W-1:SET_W];
    assign ld_set = ld_addr[SET_W-1:0];
    assign ld_tag = ld_addr[ADDR_W-1:SET_W];

    assign st_way_vld = vld_q[st_set*WAYS +: WAYS];
    assign ld_way_vld = vld_q[ld_set*WAYS +: WAYS];

    // Gather the tags of the store and load sets.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            st_way_tags[w*TAG_W +: TAG_W] = tag_q[{st_set, WAY_W'(w)}];
            ld_way_tags[w*TAG_W +: TAG_W] = tag_q[{ld_set, WAY_W'(w)}];
        end
    end

    wc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_st_lookup (
        .way_vld  (st_way_vld),
        .way_tags (st_way_tags),
        .key      (st_tag),
        .hit_vec  (st_hit_vec),
        .hit      (st_hit),
        .hit_way  (st_hit_way)
    );

    wc_alloc #(.WAYS(WAYS)) u_st_alloc (
        .way_vld  (st_way_vld),
        .full     (st_full),
        .free_way (st_free_way)
    );

    wc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ld_lookup (
        .way_vld  (ld_way_vld),
        .way_tags (ld_way_tags),
        .key      (ld_tag),
        .hit_vec  (ld_hit_vec),
        .hit      (ld_hit),
        .hit_way  (ld_hit_way)
    );

    // Store acceptance: execute phase and either a hit or a free way.
    assign st_idx   = {st_set, (st_hit ? st_hit_way : st_free_way)};
    assign st_ok    = st_valid && !phase_publish && (st_hit || !st_full);
    assign st_stall = st_valid && !st_ok;
    assign ovf_set  = st_valid && !phase_publish && !st_hit && st_full;

    // A new entry starts from zero bytes; a hit starts from its own data.
    assign st_base = st_hit ? data_q[st_idx] : '0;

    wc_merge #(.LINE_BYTES(LINE_BYTES)) u_st_merge (
        .base   (st_base),
        .over   (st_data),
        .mask   (st_mask),
        .result (st_merged)
    );

    // Load overlay of buffered bytes on L1 data.
    assign ld_idx = {ld_set, ld_hit_way};

    wc_merge #(.LINE_BYTES(LINE_BYTES)) u_ld_merge (
        .base   (ld_l1_data),
        .over   (data_q[ld_idx]),
        .mask   (mask_q[ld_idx]),
        .result (ld_merged)
    );

    assign ld_refused = ld_valid && phase_publish;
    assign ld_data    = (ld_hit && !phase_publish) ? ld_merged : ld_l1_data;

    wc_flush_ctrl #(.IDX_W(IDX_W)) u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .publish   (phase_publish),
        .ent_valid (vld_q[fl_ptr]),
        .fl_ready  (fl_ready),
        .ptr       (fl_ptr),
        .fl_valid  (fl_valid),
        .clear_en  (fl_clear),
        .scan_end  (fl_scan_end),
        .done      (flush_done)
    );

    assign fl_addr  = {tag_q[fl_ptr], fl_ptr[IDX_W-1:WAY_W]};
    assign fl_data  = data_q[fl_ptr];
    assign fl_mask  = mask_q[fl_ptr];
    assign overflow = ovf_q;

    // Entry valid bits: set on an accepted store, cleared on a flush handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (fl_clear) vld_q[fl_ptr] <= 1'b0;
            if (st_ok)    vld_q[st_idx] <= 1'b1;
        end
    end

    // Entry payload: tag, merged bytes and accumulated mask.
    always_ff @(posedge clk) begin
        if (st_ok) begin
            tag_q[st_idx]  <= st_tag;
            data_q[st_idx] <= st_merged;
            mask_q[st_idx] <= (st_hit ? mask_q[st_idx] : '0) | st_mask;
        end
    end

    // Overflow flag: raised by a full-set miss, dropped at flush completion.
    always_ff @(posedge clk) begin
        if (!rst_n)           ovf_q <= 1'b0;
        else if (fl_scan_end) ovf_q <= 1'b0;
        else if (ovf_set)     ovf_q <= 1'b1;
    end

    // R3: a line is never held by two ways of its set.
    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit_vec) && $onehot0(ld_hit_vec));

    // R6: overflow, once raised, persists until the scan finishes.
    a_r6_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !fl_scan_end) |=> ovf_q);

    // R7: no entry becomes valid while publish is active.
    a_r7_no_alloc_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_publish && $past(phase_publish)) |-> ((vld_q & ~$past(vld_q)) == '0));

    // R8: an offered line keeps its address and bytes until taken.
    a_r8_stable_line: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_ready) |=> ($stable(fl_addr) && $stable(fl_data) && $stable(fl_mask)));

    // R9: at the done pulse the array is empty and overflow is clear.
    a_r9_empty_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> ((vld_q == '0) && !ovf_q));

endmodule

// File: tb/wcache_coalesce_tb_top.sv
// Bench for wcache_coalesce on a 2-set, 2-way, 4-byte-line build. A small
// reference model of the array predicts stalls, forwarded bytes and the
// exact flush order; all results are counted and summarised.
module wcache_coalesce_tb_top;

    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_publish = 1'b0;
    logic        st_valid = 1'b0;
    logic [7:0]  st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_mask = '0;
    logic        st_stall;
    logic        ld_valid = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_l1_data = '0;
    logic [31:0] ld_data;
    logic        ld_refused;
    logic        fl_valid;
    logic        fl_ready = 1'b0;
    logic [7:0]  fl_addr;
    logic [31:0] fl_data;
    logic [3:0]  fl_mask;
    logic        flush_done;
    logic        overflow;

    int nchk = 0;
    int nfail = 0;

    // Reference model of the entries, index = set*2 + way.
    bit          mv   [NE];
    logic [7:0]  maddr[NE];
    logic [31:0] mdata[NE];
    logic [3:0]  mmask[NE];
    logic [15:0] lfsr = 16'hACE1;

    wcache_coalesce #(.SETS(2), .WAYS(2), .LINE_BYTES(4), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_publish(phase_publish),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
        .st_stall(st_stall), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_l1_data(ld_l1_data), .ld_data(ld_data), .ld_refused(ld_refused),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_addr(fl_addr),
        .fl_data(fl_data), .fl_mask(fl_mask), .flush_done(flush_done),
        .overflow(overflow)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [7:0] a);
        for (int w = 0; w < 2; w++) begin
            if (mv[a[0]*2 + w] && maddr[a[0]*2 + w] == a) return a[0]*2 + w;
        end
        return -1;
    endfunction

    function automatic int m_free(input logic [7:0] a);
        for (int w = 0; w < 2; w++) begin
            if (!mv[a[0]*2 + w]) return a[0]*2 + w;
        end
        return -1;
    endfunction

    function automatic logic [31:0] overlay(input logic [31:0] base, input logic [31:0] over, input logic [3:0] m);
        logic [31:0] r = base;
        for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = over[b*8 +: 8];
        return r;
    endfunction

    // Store with stall prediction; the model is updated only when accepted.
    task automatic do_store(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m,
                            input string req, output bit stalled);
        int h;
        int f;
        bit exp_stall;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
        #5;
        h = m_find(a);
        f = m_free(a);
        exp_stall = phase_publish || (h < 0 && f < 0);
        check(st_stall == exp_stall, req, {31'd0, st_stall}, {31'd0, exp_stall});
        @(posedge clk);
        #1;
        st_valid = 1'b0;
        stalled = exp_stall;
        if (!exp_stall) begin
            if (h >= 0) begin
                mdata[h] = overlay(mdata[h], d, m);
                mmask[h] = mmask[h] | m;
            end else begin
                mv[f] = 1'b1; maddr[f] = a;
                mdata[f] = overlay(32'd0, d, m);
                mmask[f] = m;
            end
        end
    endtask

    // Load lookup compared against the model.
    task automatic check_load(input logic [7:0] a, input logic [31:0] l1, input string req);
        int h;
        logic [31:0] exp_d;
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_l1_data = l1;
        #5;
        h = m_find(a);
        exp_d = (!phase_publish && h >= 0) ? overlay(l1, mdata[h], mmask[h]) : l1;
        check(ld_data == exp_d, req, ld_data, exp_d);
        check(ld_refused == phase_publish, req, {31'd0, ld_refused}, {31'd0, phase_publish});
        ld_valid = 1'b0;
    endtask

    // Publish flush: mode 1 keeps ready high, mode 0 stutters it.
    task automatic run_flush(input int mode);
        int order[NE];
        int n = 0;
        int k = 0;
        bit seen = 1'b0;
        bit hold = 1'b0;
        logic [7:0] hold_addr = '0;
        for (int i = 0; i < NE; i++) if (mv[i]) begin order[n] = i; n++; end
        @(negedge clk);
        phase_publish = 1'b1;
        for (int cyc = 0; cyc < 200; cyc++) begin
            @(negedge clk);
            fl_ready = (mode == 1) ? 1'b1 : ((cyc % 3) != 2);
            #2;
            if (flush_done) begin seen = 1'b1; break; end
            if (hold) check(fl_addr == hold_addr, "R8 held line changed", {24'd0, fl_addr}, {24'd0, hold_addr});
            hold = 1'b0;
            if (fl_valid) begin
                if (k < n) begin
                    check(fl_addr == maddr[order[k]], "R2/R8 flush address", {24'd0, fl_addr}, {24'd0, maddr[order[k]]});
                    check(fl_data == mdata[order[k]], "R2/R8 flush data", fl_data, mdata[order[k]]);
                    check(fl_mask == mmask[order[k]], "R8 flush mask", {28'd0, fl_mask}, {28'd0, mmask[order[k]]});
                end else begin
                    check(1'b0, "R8 extra flush line", {24'd0, fl_addr}, 32'd0);
                end
                if (fl_ready) k++;
                else begin hold = 1'b1; hold_addr = fl_addr; end
            end
        end
        fl_ready = 1'b0;
        check(seen, "R9 done pulse seen", {31'd0, seen}, 32'd1);
        check(k == n, "R9 lines before done", k, n);
        check(!overflow, "R9 overflow cleared", {31'd0, overflow}, 32'd0);
        @(negedge clk);
        check(!flush_done, "R9 done lasts one cycle", {31'd0, flush_done}, 32'd0);
        phase_publish = 1'b0;
        for (int i = 0; i < NE; i++) mv[i] = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=0", 100000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        bit stl;
        bit any_stall;
        for (int i = 0; i < NE; i++) begin mv[i] = 1'b0; maddr[i] = '0; mdata[i] = '0; mmask[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        #2;
        check(!fl_valid, "R1 fl_valid", {31'd0, fl_valid}, 32'd0);
        check(!overflow, "R1 overflow", {31'd0, overflow}, 32'd0);
        check(!flush_done, "R1 flush_done", {31'd0, flush_done}, 32'd0);
        check(!st_stall, "R1 st_stall", {31'd0, st_stall}, 32'd0);
        check_load(8'h10, 32'h0BADF00D, "R1 load after reset");

        // R2/R3/R4: sweep all non-zero masks into one line with forwarding.
        for (int m = 1; m < 16; m++) begin
            do_store(8'h10, {4{8'(m * 17)}}, 4'(m), "R2/R3 store accepted", stl);
            check_load(8'h10, 32'hA5A5A5A5, "R3/R4 merged forward");
        end

        // R2: fill set 0 way 1 and set 1; R4 miss path.
        do_store(8'h21, 32'h11223344, 4'b0101, "R2 new line set1", stl);
        do_store(8'h12, 32'hCAFEBABE, 4'b1000, "R2 new line set0 way1", stl);
        check_load(8'h30, 32'h5A5A5A5A, "R4 miss returns l1");
        check_load(8'h21, 32'hFFFFFFFF, "R4 hit partial mask");

        // R6: full-set miss stalls and raises overflow; contents unchanged.
        do_store(8'h14, 32'hDEADBEEF, 4'b1111, "R6 full set stall", stl);
        check(overflow, "R6 overflow raised", {31'd0, overflow}, 32'd1);
        check_load(8'h14, 32'h01010101, "R6 stalled store not written");
        check_load(8'h10, 32'h02020202, "R6 other line unchanged");
        check(overflow, "R6 overflow held", {31'd0, overflow}, 32'd1);

        // R5/R7: publish refuses loads and stalls stores.
        fl_ready = 1'b0;
        @(negedge clk);
        phase_publish = 1'b1;
        check_load(8'h10, 32'h77777777, "R5 load refused");
        do_store(8'h21, 32'h99999999, 4'b1111, "R7 store stalled in publish", stl);
        run_flush(0);

        // R9: array empty after flush.
        check_load(8'h10, 32'h13572468, "R9 line gone after flush");
        check_load(8'h21, 32'h13572468, "R9 line gone after flush");

        // R10: replay of the stalled store succeeds.
        do_store(8'h14, 32'hDEADBEEF, 4'b1111, "R10 replay accepted", stl);
        check_load(8'h14, 32'h00000000, "R10 replay forwarded");
        check(!overflow, "R10 overflow stays clear", {31'd0, overflow}, 32'd0);
        run_flush(1);

        // R9: empty-array flush still completes.
        run_flush(0);

        // Pseudo-random rounds over eight lines mapping to two sets.
        for (int round = 0; round < 4; round++) begin
            any_stall = 1'b0;
            for (int s = 0; s < 12; s++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                do_store({5'd0, lfsr[2:0]}, {lfsr, lfsr ^ 16'h5555},
                         (lfsr[7:4] == 4'd0) ? 4'b0001 : lfsr[7:4], "R6/R3 random store", stl);
                any_stall = any_stall | stl;
            end
            check(overflow == any_stall, "R6 overflow after round", {31'd0, overflow}, {31'd0, any_stall});
            for (int a = 0; a < 8; a++) check_load(8'(a), 32'hC3C3C3C3, "R4 random forward");
            run_flush(round % 2);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule